// File: doc/BRIEF.md
# Keyed Windowed Watchdog Timer

This block supervises a processor by counting instruction-cycle ticks. Software proves it is alive by writing an 8-bit service word. The word holds a window-select field, a fixed key pattern and a clock-monitor enable bit. A service counts as good only when two conditions hold. First, the fields must match. Second, it must arrive inside a time window that opens a fixed number of ticks after the window starts and closes at an upper limit set by the selected window. A good service restarts the window. A bad service, or letting the window run out, produces a one-clock error pulse and restarts the window.

The configuration is write-once. After reset the largest window is active and the clock monitor is enabled. The first service only has to carry the right key, may arrive at any time, and fixes the window and clock-monitor choice until the next reset. The counter freezes while the processor is halted or idle. When the processor wakes, the mode it was in and the oscillator straps decide whether the window restarts or carries on.

Top module: `svc_watchdog`

## Requirements
- R1: After reset the read port returns 8'hC1 (window code 3, key field zero, clock-monitor enable 1) and the error output is low.
- R2: The service word is laid out as window code in bits [7:6], key in bits [5:1] and clock-monitor enable in bit [0]. The key is 5'b01100. The first service after reset only has to carry that key, even before the lower bound. It then stores the window code and enable bit and raises no error.
- R3: Every later service must equal the stored word exactly (window code, key 01100 and enable bit). Any differing bit causes an error pulse.
- R4: A later service with fewer than LOWER_TICKS counted ticks since the window started is an error, even when the word matches.
- R5: If the count reaches the upper limit without a good service, the error pulse comes in the cycle after the tick that reached the limit. Only cycles with tick_en high count.
- R6: The upper limit is BASE_UPPER shifted left by the window code (1x, 2x, 4x or 8x).
- R7: A good service raises no error and restarts the count from zero.
- R8: The key field of rd_data always reads as zero.
- R9: While halt_i or idle_i is high the count holds, writes are ignored and no error is raised.
- R10: In the first cycle with both mode inputs low after idle, the window restarts from zero. Tick and write are ignored in that cycle.
- R11: In the first cycle with both mode inputs low after halt only, the window restarts if osc_xtal_i or clk_dly_i is high, and otherwise resumes from the held count. Tick and write are ignored in that cycle.
- R12: The error output is high for one clock per error event. After an error the count restarts under the current settings. A rejected first service leaves the configuration open.
- R13: Once the first good service has been taken, later writes never change the stored window code or enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One instruction-cycle tick |
| wr_en | input | 1 | Service write strobe |
| wr_data | input | 8 | Service word |
| rd_data | output | 8 | Stored word with the key field masked |
| halt_i | input | 1 | Processor in halt mode |
| idle_i | input | 1 | Processor in idle mode |
| osc_xtal_i | input | 1 | Strap: 1 = crystal oscillator, 0 = RC oscillator |
| clk_dly_i | input | 1 | Clock-delay configuration bit |
| wd_err_o | output | 1 | One-clock watchdog error pulse |

## Verification
The bench builds the block with LOWER_TICKS = 8 and BASE_UPPER = 32, which gives upper limits of 32, 64, 128 and 256 ticks. With these values every timeout, early-service and wake case completes in a few dozen cycles. Exact timeout distances can then be checked for the resume and restart paths. A long random stretch of sleep and service traffic can also be compared against a behavioural model cycle by cycle. The wider default counter differs only in width, so the same paths are exercised.

// File: rtl/svc_wdog_pkg.sv
package svc_wdog_pkg;
  localparam logic [4:0] SVC_KEY = 5'b01100;

  typedef struct packed {
    logic [1:0] win;
    logic [4:0] key;
    logic       cmon;
  } svc_word_t;
endpackage

// File: rtl/wdog_win_ctr.sv
module wdog_win_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [CNT_W:0]   limit,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W:0]   last;

  assign last   = limit - 1'b1;
  assign expire = adv && ({1'b0, cnt} == last);

  always_comb begin
    cnt_d = cnt;
    if (clr) begin
      cnt_d = '0;
    end else if (adv) begin
      if (expire) cnt_d = '0;
      else        cnt_d = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] win_in,
  input  logic       cmon_in,
  output logic [1:0] win,
  output logic       cmon,
  output logic       first
);
  logic [1:0] win_d;
  logic       cmon_d;
  logic       first_d;

  always_comb begin
    win_d   = win;
    cmon_d  = cmon;
    first_d = first;
    if (load && first) begin
      win_d   = win_in;
      cmon_d  = cmon_in;
      first_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win   <= 2'b11;
      cmon  <= 1'b1;
      first <= 1'b1;
    end else begin
      win   <= win_d;
      cmon  <= cmon_d;
      first <= first_d;
    end
  end
endmodule

// File: rtl/wdog_svc_judge.sv
module wdog_svc_judge
  import svc_wdog_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int LOWER_TICKS = 2048
) (
  input  logic [7:0]       word,
  input  logic [1:0]       win,
  input  logic             cmon,
  input  logic             first,
  input  logic [CNT_W-1:0] cnt,
  output logic             svc_ok
);
  svc_word_t got;
  svc_word_t want;
  logic      in_window;

  assign got       = svc_word_t'(word);
  assign want      = '{win: win, key: SVC_KEY, cmon: cmon};
  assign in_window = (cnt >= CNT_W'(LOWER_TICKS));

  always_comb begin
    if (first) svc_ok = (got.key == SVC_KEY);
    else       svc_ok = (got == want) && in_window;
  end
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog #(
  parameter int LOWER_TICKS = 2048,
  parameter int BASE_UPPER  = 8192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       halt_i,
  input  logic       idle_i,
  input  logic       osc_xtal_i,
  input  logic       clk_dly_i,
  output logic       wd_err_o
);
  localparam int             CNT_W  = $clog2(BASE_UPPER) + 3;
  localparam logic [CNT_W:0] BASE_L = (CNT_W + 1)'(BASE_UPPER);

  logic             halt_q, idle_q;
  logic             asleep, wake, active;
  logic             svc, adv, clr, svc_ok, expire;
  logic             err_d, err_q;
  logic [1:0]       win;
  logic             cmon, first;
  logic [CNT_W:0]   limit;
  logic [CNT_W-1:0] cnt;

  assign asleep = halt_i | idle_i;
  assign wake   = (halt_q | idle_q) & ~asleep;
  assign active = ~asleep & ~wake;
  assign svc    = active & wr_en;
  assign adv    = active & ~wr_en & tick_en;
  assign clr    = svc | (wake & (idle_q | osc_xtal_i | clk_dly_i));
  assign limit  = BASE_L << win;
  assign err_d  = (svc & ~svc_ok) | expire;

  wdog_win_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv),
    .limit(limit), .cnt(cnt), .expire(expire)
  );

  wdog_svc_judge #(.CNT_W(CNT_W), .LOWER_TICKS(LOWER_TICKS)) u_judge (
    .word(wr_data), .win(win), .cmon(cmon), .first(first),
    .cnt(cnt), .svc_ok(svc_ok)
  );

  wdog_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .load(svc & svc_ok),
    .win_in(wr_data[7:6]), .cmon_in(wr_data[0]),
    .win(win), .cmon(cmon), .first(first)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
      idle_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      halt_q <= halt_i;
      idle_q <= idle_i;
      err_q  <= err_d;
    end
  end

  assign wd_err_o = err_q;
  assign rd_data  = {win, 5'b00000, cmon};
endmodule

// File: rtl/svc_watchdog_chk.sv
module svc_watchdog_chk #(
  parameter int CNT_W       = 16,
  parameter int LOWER_TICKS = 2048
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wd_err_o,
  input logic [7:0]       rd_data,
  input logic             halt_i,
  input logic             idle_i,
  input logic             svc,
  input logic             first,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W:0]   limit
);
  AST_KEY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[5:1] == 5'd0); // R8

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt} < limit); // R5

  AST_EARLY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (svc && !first && cnt < CNT_W'(LOWER_TICKS)) |=> wd_err_o); // R4

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i || idle_i) |=> !wd_err_o); // R9

  AST_SLEEP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i || idle_i) |=> $stable(cnt)); // R9

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!first && !$past(first)) |-> $stable(rd_data)); // R13

  AST_ERR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    wd_err_o |-> cnt == '0); // R12
endmodule

bind svc_watchdog svc_watchdog_chk #(.CNT_W(CNT_W), .LOWER_TICKS(LOWER_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wd_err_o(wd_err_o), .rd_data(rd_data),
  .halt_i(halt_i), .idle_i(idle_i), .svc(svc), .first(first),
  .cnt(cnt), .limit(limit)
);

// File: tb/tb_svc_watchdog.sv
module tb_svc_watchdog;
  localparam int LOW  = 8;
  localparam int BASE = 32;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en, wr_en, halt_i, idle_i, osc_xtal_i, clk_dly_i;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       wd_err_o;

  int vectors = 0;
  int miscompares = 0;
  bit mon_on = 0;

  always #5 clk = ~clk;

  svc_watchdog #(.LOWER_TICKS(LOW), .BASE_UPPER(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .halt_i(halt_i), .idle_i(idle_i),
    .osc_xtal_i(osc_xtal_i), .clk_dly_i(clk_dly_i), .wd_err_o(wd_err_o)
  );

  // behavioural reference
  int       m_cnt;
  bit       m_first, m_cmon, m_err, m_hq, m_iq;
  bit [1:0] m_win;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_first = 1; m_win = 3; m_cmon = 1; m_err = 0; m_hq = 0; m_iq = 0;
    end else begin
      bit good;
      int lim;
      lim   = BASE * (1 << m_win);
      m_err = 0;
      if ((m_hq || m_iq) && !halt_i && !idle_i) begin
        if (m_iq || osc_xtal_i || clk_dly_i) m_cnt = 0;
      end else if (!halt_i && !idle_i) begin
        if (wr_en) begin
          if (m_first) good = (wr_data[5:1] == 5'b01100);
          else good = (wr_data == {m_win, 5'b01100, m_cmon}) && (m_cnt >= LOW);
          if (good && m_first) begin
            m_win = wr_data[7:6]; m_cmon = wr_data[0]; m_first = 0;
          end
          if (!good) m_err = 1;
          m_cnt = 0;
        end else if (tick_en) begin
          if (m_cnt + 1 == lim) begin m_err = 1; m_cnt = 0; end
          else m_cnt = m_cnt + 1;
        end
      end
      m_hq = halt_i; m_iq = idle_i;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      chk("R12 model err", {7'd0, wd_err_o}, {7'd0, m_err});
      chk("R13 model rd_data", rd_data, {m_win, 5'd0, m_cmon});
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic svc(logic [7:0] d);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic to_err(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!wd_err_o && n < 2000);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog R5 actual=hung expected=done");
    summary();
  end

  initial begin
    int n;
    rst_n = 0; tick_en = 0; wr_en = 0; wr_data = 0;
    halt_i = 0; idle_i = 0; osc_xtal_i = 0; clk_dly_i = 0;
    wait_n(3);
    rst_n = 1;
    @(negedge clk);
    mon_on = 1;
    chk("R1 reset rd_data", rd_data, 8'hC1);
    chk("R1 reset err", {7'd0, wd_err_o}, 8'd0);
    tick_en = 1;

    svc(8'hDA);                      // wrong key on first service
    chk("R12 bad first err", {7'd0, wd_err_o}, 8'd1);
    chk("R12 config still open", rd_data, 8'hC1);
    @(negedge clk);
    chk("R12 single pulse", {7'd0, wd_err_o}, 8'd0);

    svc(8'h59);                      // early first service, window 1, cmon 1
    chk("R2 first early no err", {7'd0, wd_err_o}, 8'd0);
    chk("R2 config stored", rd_data, 8'h41);
    chk("R8 key masked", {3'd0, rd_data[5:1]}, 8'd0);

    wait_n(20);
    svc(8'h59);
    chk("R7 good service no err", {7'd0, wd_err_o}, 8'd0);
    to_err(n);
    chk("R6 timeout distance window 1", n[7:0], 8'd64);

    wait_n(3);
    svc(8'h59);
    chk("R4 early service err", {7'd0, wd_err_o}, 8'd1);

    wait_n(10);
    svc(8'h5B);
    chk("R3 wrong key err", {7'd0, wd_err_o}, 8'd1);

    wait_n(10);
    svc(8'hD9);
    chk("R13 window change err", {7'd0, wd_err_o}, 8'd1);
    chk("R13 window unchanged", rd_data, 8'h41);

    wait_n(10);
    svc(8'h58);
    chk("R3 cmon mismatch err", {7'd0, wd_err_o}, 8'd1);

    // halt with RC, no delay: resume
    wait_n(10);
    halt_i = 1;
    repeat (5) begin
      svc(8'h00);
      chk("R9 write ignored in halt", {7'd0, wd_err_o}, 8'd0);
    end
    wait_n(40);
    halt_i = 0;
    to_err(n);
    chk("R11 halt resume distance", n[7:0], 8'd55);

    // halt with crystal: restart
    wait_n(10); svc(8'h59); wait_n(20);
    osc_xtal_i = 1; halt_i = 1; wait_n(30); halt_i = 0;
    to_err(n);
    chk("R11 halt crystal restart", n[7:0], 8'd65);
    osc_xtal_i = 0;

    // halt with RC and delay bit: restart
    wait_n(10); svc(8'h59); wait_n(20);
    clk_dly_i = 1; halt_i = 1; wait_n(30); halt_i = 0;
    to_err(n);
    chk("R11 halt delay restart", n[7:0], 8'd65);
    clk_dly_i = 0;

    // idle: restart
    wait_n(10); svc(8'h59); wait_n(20);
    idle_i = 1; wait_n(30); idle_i = 0;
    to_err(n);
    chk("R10 idle restart", n[7:0], 8'd65);

    // random traffic against the model (R5 tick gating, R9 sleep)
    begin
      int mode_left = 0;
      for (int i = 0; i < 4000; i++) begin
        tick_en = ($urandom_range(0, 3) != 0);
        if (mode_left > 0) begin
          mode_left--;
          if (mode_left == 0) begin halt_i = 0; idle_i = 0; end
        end else if ($urandom_range(0, 299) == 0) begin
          osc_xtal_i = $urandom_range(0, 1);
          clk_dly_i  = $urandom_range(0, 1);
          if ($urandom_range(0, 1) != 0) halt_i = 1; else idle_i = 1;
          mode_left = $urandom_range(5, 40);
        end
        if ($urandom_range(0, 39) == 0) begin
          wr_en = 1;
          case ($urandom_range(0, 4))
            0, 1:    wr_data = 8'h59;
            2:       wr_data = 8'h5B;
            3:       wr_data = 8'hD9;
            default: wr_data = 8'($urandom);
          endcase
        end else wr_en = 0;
        @(negedge clk);
      end
      wr_en = 0; halt_i = 0; idle_i = 0;
      wait_n(2);
    end
    summary();
  end
endmodule